// File: doc/BRIEF.md
# Write CRC Command Legality Monitor

This block observes a decoded memory command stream together with the write-side mode settings. It reports protocol misuse that becomes illegal once write data CRC checking is switched on. It counts clocks since the most recent write in every bank group, and also since the most recent write in any group. A write that lands at the one spacing the current write preamble length forbids is flagged, whether the earlier write was in the same bank group or in another one. The monitor also flags two other cases while CRC is on: a special-register write command and per-device addressing mode. It flags write inversion combined with data masking as a configuration conflict.

Every rule has its own sticky flag. A three-bit code names the first rule that fired. Flags and code hold until a synchronous clear. The monitor does not execute commands. It only observes them, so it can be placed beside a controller or a bus model.

Top module: `wcrc_cmd_monitor`

## Requirements
- R1: A command is taken only when `cmd_valid` is 1, and `cmd_type` 3'd1 means write. With `crc_en`=1 and `wr_pre_2tck`=0, a write to a bank group exactly 4 clocks after the previous write to that same group sets flag bit 0 and code 1. Reads (3'd2) and other spacings are not flagged.
- R2: With `crc_en`=1 and `wr_pre_2tck`=1, the forbidden same-group spacing is 6 clocks and a spacing of 4 is legal. With `wr_pre_2tck`=0, a spacing of 6 is legal.
- R3: A write to a group other than the group of the most recent write, exactly at the forbidden spacing (4 or 6, as selected in R2) after that most recent write, sets flag bit 1 and code 2.
- R4: With `crc_en`=1, any valid command with `cmd_type` 3'd3 (special-register write) sets flag bit 2 and code 3.
- R5: With `crc_en`=1, `pda_en`=1 sets flag bit 3 and code 4 in every cycle it is held.
- R6: With `crc_en`=1, `wr_dbi_en`=1 together with `dm_en`=1 sets flag bit 4 and code 5. `rd_dbi_en`=1 together with `dm_en`=1 sets nothing.
- R7: Spacing counters saturate at 15. Writes separated by more than 15 clocks, including 20 clocks, are never flagged. After such a pause the next forbidden spacing is still caught.
- R8: With `crc_en`=0 no rule sets any flag. Writes made while CRC is off still count as history for the spacing rules once CRC is back on.
- R9: A flag appears on the clock edge that follows the offending input. Flags accumulate and stay set until cleared.
- R10: `viol_code` holds the code of the first violation after a clear or reset. If several rules fire in that first cycle, the lowest code wins. Later violations never change the code.
- R11: `clear`=1 zeroes flags and code at the next edge. A violation in the same cycle as the clear is discarded.
- R12: Synchronous active-low reset zeroes flags and code and erases all write history, so the first write after reset is never a spacing violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clear | input | 1 | Synchronous clear of flags and code |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_type | input | 3 | 1 write, 2 read, 3 special-register write, other values ignored |
| bank_group | input | BG_W (2) | Bank group of the command |
| wr_pre_2tck | input | 1 | 1 selects the two-clock write preamble, 0 the one-clock preamble |
| crc_en | input | 1 | Write CRC enabled |
| wr_dbi_en | input | 1 | Write data inversion enabled |
| rd_dbi_en | input | 1 | Read data inversion enabled (legal with masking) |
| dm_en | input | 1 | Data masking enabled |
| pda_en | input | 1 | Per-device addressing mode enabled |
| viol_flags | output | 5 | Sticky flags: bit0 same-group spacing, bit1 cross-group spacing, bit2 special-register write, bit3 per-device addressing, bit4 inversion/mask conflict |
| viol_code | output | 3 | Code of the first violation, 0 when none |

## Verification
Any fault in the history counters shows up as a spacing flag that is missing or spurious on the edge after the second write. A counter that wraps instead of saturating is exposed by a 20-clock gap, which aliases to the forbidden 4. A wrong last-group register misroutes a hit between bit 0 and bit 1. Faults in the sticky log appear one cycle later, as a code that changes after the first violation or a flag that drops without a clear.

// File: rtl/wcrc_mon_pkg.sv
// Shared definitions for the write CRC command legality monitor.
// Assumes rule indices map to codes as index+1, lowest code has priority.
package wcrc_mon_pkg;

    localparam int NUM_RULES = 5;

    // Rule positions inside the violation vector
    localparam int RULE_SAME_GAP  = 0;
    localparam int RULE_CROSS_GAP = 1;
    localparam int RULE_SPREG_WR  = 2;
    localparam int RULE_PDA       = 3;
    localparam int RULE_DBI_DM    = 4;

    typedef enum logic [2:0] {
        CMD_NONE     = 3'd0,
        CMD_WRITE    = 3'd1,
        CMD_READ     = 3'd2,
        CMD_SPREG_WR = 3'd3
    } cmd_e;

    typedef logic [NUM_RULES-1:0] rule_vec_t;

    // Code of the lowest-numbered rule set in v, 0 when v is empty
    function automatic logic [2:0] first_code(input rule_vec_t v);
        logic [2:0] c;
        c = 3'd0;
        for (int i = NUM_RULES - 1; i >= 0; i--) begin
            if (v[i]) c = 3'(i + 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/wcrc_gap_tracker.sv
// Clock-distance tracker for write commands.
// Keeps one saturating counter per bank group plus one for any group, and
// the group of the most recent write. Counter value N means the last write
// was N clocks ago; reset loads the saturated value (no history).
// Assumes bank group values at or above NUM_BG never occur.
module wcrc_gap_tracker #(
    parameter int NUM_BG = 4,
    parameter int BG_W   = 2,
    parameter int CNT_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_fire,
    input  logic [BG_W-1:0]  wr_bg,
    output logic [CNT_W-1:0] same_gap,
    output logic [CNT_W-1:0] glob_gap,
    output logic [BG_W-1:0]  last_bg
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] grp_cnt [NUM_BG];

    for (genvar g = 0; g < NUM_BG; g++) begin : g_grp
        logic hit;
        assign hit = wr_fire && (wr_bg == BG_W'(g));

        // Per-group distance since the last write to this group
        always_ff @(posedge clk) begin
            if (!rst_n)                 grp_cnt[g] <= CNT_MAX;
            else if (hit)               grp_cnt[g] <= CNT_ONE;
            else if (grp_cnt[g] != CNT_MAX) grp_cnt[g] <= grp_cnt[g] + CNT_ONE;
        end

        // R7
        grp_sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (grp_cnt[g] == CNT_MAX && !hit) |=> (grp_cnt[g] == CNT_MAX));
    end

    // Distance since the last write to any group, and that write's group
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glob_gap <= CNT_MAX;
            last_bg  <= '0;
        end else if (wr_fire) begin
            glob_gap <= CNT_ONE;
            last_bg  <= wr_bg;
        end else if (glob_gap != CNT_MAX) begin
            glob_gap <= glob_gap + CNT_ONE;
        end
    end

    // Select the counter of the group addressed by the current command
    always_comb begin
        same_gap = CNT_MAX;
        for (int g = 0; g < NUM_BG; g++) begin
            if (wr_bg == BG_W'(g)) same_gap = grp_cnt[g];
        end
    end

    // R7
    glob_sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_gap == CNT_MAX && !wr_fire) |=> (glob_gap == CNT_MAX));

    // R3
    last_bg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_fire |=> $stable(last_bg));

endmodule

// File: rtl/wcrc_rule_eval.sv
// Combinational rule evaluation for the current cycle.
// Produces one bit per rule, all gated by the CRC enable. Spacing rules
// compare tracker distances with the spacing the preamble mode forbids.
// Assumes both forbidden spacings are below the counter saturation value.
module wcrc_rule_eval
    import wcrc_mon_pkg::*;
#(
    parameter int BG_W       = 2,
    parameter int CNT_W      = 4,
    parameter int SPACE_1TCK = 4,
    parameter int SPACE_2TCK = 6
) (
    input  logic             crc_en,
    input  logic             wr_fire,
    input  logic             spreg_fire,
    input  logic [BG_W-1:0]  wr_bg,
    input  logic [BG_W-1:0]  last_bg,
    input  logic [CNT_W-1:0] same_gap,
    input  logic [CNT_W-1:0] glob_gap,
    input  logic             wr_pre_2tck,
    input  logic             wr_dbi_en,
    input  logic             dm_en,
    input  logic             pda_en,
    output rule_vec_t        hits
);

    localparam logic [CNT_W-1:0] GAP_1TCK = CNT_W'(SPACE_1TCK);
    localparam logic [CNT_W-1:0] GAP_2TCK = CNT_W'(SPACE_2TCK);

    logic [CNT_W-1:0] forbid_gap;

    // Forbidden write spacing for the current preamble length
    always_comb forbid_gap = wr_pre_2tck ? GAP_2TCK : GAP_1TCK;

    // One bit per rule, nothing reported while CRC is off
    always_comb begin
        hits = '0;
        if (crc_en) begin
            hits[RULE_SAME_GAP]  = wr_fire && (same_gap == forbid_gap);
            hits[RULE_CROSS_GAP] = wr_fire && (wr_bg != last_bg) && (glob_gap == forbid_gap);
            hits[RULE_SPREG_WR]  = spreg_fire;
            hits[RULE_PDA]       = pda_en;
            hits[RULE_DBI_DM]    = wr_dbi_en && dm_en;
        end
    end

endmodule

// File: rtl/wcrc_sticky_log.sv
// Sticky violation record.
// Flags accumulate every rule hit; the code records the first violation
// (lowest code on a tie). A synchronous clear beats same-cycle hits.
module wcrc_sticky_log
    import wcrc_mon_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clear,
    input  rule_vec_t hits,
    output rule_vec_t flags_q,
    output logic [2:0] code_q
);

    // Accumulate flags and latch the first code
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            flags_q <= '0;
            code_q  <= 3'd0;
        end else begin
            flags_q <= flags_q | hits;
            if (flags_q == '0 && hits != '0) code_q <= first_code(hits);
        end
    end

    // R9
    flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && flags_q != '0) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    // R10
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && code_q != 3'd0) |=> (code_q == $past(code_q)));

    // R10
    code_flag_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((code_q != 3'd0) == (flags_q != '0)));

    // R11
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (flags_q == '0 && code_q == 3'd0));

endmodule

// File: rtl/wcrc_cmd_monitor.sv
// Write CRC command legality monitor, top level.
// Decodes the command strobe, feeds the distance tracker, evaluates the
// rules and keeps sticky results. Observes only; drives nothing back.
// Assumes inputs are synchronous to clk and one command per cycle at most.
module wcrc_cmd_monitor
    import wcrc_mon_pkg::*;
#(
    parameter int NUM_BG     = 4,
    parameter int BG_W       = (NUM_BG > 1) ? $clog2(NUM_BG) : 1,
    parameter int CNT_W      = 4,
    parameter int SPACE_1TCK = 4,
    parameter int SPACE_2TCK = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 cmd_valid,
    input  logic [2:0]           cmd_type,
    input  logic [BG_W-1:0]      bank_group,
    input  logic                 wr_pre_2tck,
    input  logic                 crc_en,
    input  logic                 wr_dbi_en,
    input  logic                 rd_dbi_en,
    input  logic                 dm_en,
    input  logic                 pda_en,
    output logic [NUM_RULES-1:0] viol_flags,
    output logic [2:0]           viol_code
);

    logic             wr_fire;
    logic             spreg_fire;
    logic [CNT_W-1:0] same_gap;
    logic [CNT_W-1:0] glob_gap;
    logic [BG_W-1:0]  last_bg;
    rule_vec_t        hits;
    rule_vec_t        flags_q;
    logic             rd_dbi_unused;

    // Read inversion takes part in no rule; it is legal with masking
    assign rd_dbi_unused = rd_dbi_en;

    // Command decode
    always_comb begin
        wr_fire    = cmd_valid && (cmd_e'(cmd_type) == CMD_WRITE);
        spreg_fire = cmd_valid && (cmd_e'(cmd_type) == CMD_SPREG_WR);
    end

    wcrc_gap_tracker #(
        .NUM_BG (NUM_BG),
        .BG_W   (BG_W),
        .CNT_W  (CNT_W)
    ) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_fire  (wr_fire),
        .wr_bg    (bank_group),
        .same_gap (same_gap),
        .glob_gap (glob_gap),
        .last_bg  (last_bg)
    );

    wcrc_rule_eval #(
        .BG_W       (BG_W),
        .CNT_W      (CNT_W),
        .SPACE_1TCK (SPACE_1TCK),
        .SPACE_2TCK (SPACE_2TCK)
    ) u_rules (
        .crc_en      (crc_en),
        .wr_fire     (wr_fire),
        .spreg_fire  (spreg_fire),
        .wr_bg       (bank_group),
        .last_bg     (last_bg),
        .same_gap    (same_gap),
        .glob_gap    (glob_gap),
        .wr_pre_2tck (wr_pre_2tck),
        .wr_dbi_en   (wr_dbi_en),
        .dm_en       (dm_en),
        .pda_en      (pda_en),
        .hits        (hits)
    );

    wcrc_sticky_log u_log (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .hits    (hits),
        .flags_q (flags_q),
        .code_q  (viol_code)
    );

    assign viol_flags = flags_q;

    // R8
    crc_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!crc_en && !clear && flags_q == '0) |=> (viol_flags == '0));

    // R6
    rd_dbi_mask_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && flags_q == '0 && !cmd_valid && !pda_en && !wr_dbi_en
         && rd_dbi_unused && dm_en) |=> (viol_flags == '0));

    // R4
    spreg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_en && spreg_fire && !clear) |=> viol_flags[RULE_SPREG_WR]);

endmodule

// File: tb/wcrc_cmd_monitor_test.sv
module wcrc_cmd_monitor_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       clear;
    logic       cmd_valid;
    logic [2:0] cmd_type;
    logic [1:0] bank_group;
    logic       wr_pre_2tck;
    logic       crc_en;
    logic       wr_dbi_en;
    logic       rd_dbi_en;
    logic       dm_en;
    logic       pda_en;
    logic [4:0] viol_flags;
    logic [2:0] viol_code;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    wcrc_cmd_monitor uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear),
        .cmd_valid   (cmd_valid),
        .cmd_type    (cmd_type),
        .bank_group  (bank_group),
        .wr_pre_2tck (wr_pre_2tck),
        .crc_en      (crc_en),
        .wr_dbi_en   (wr_dbi_en),
        .rd_dbi_en   (rd_dbi_en),
        .dm_en       (dm_en),
        .pda_en      (pda_en),
        .viol_flags  (viol_flags),
        .viol_code   (viol_code)
    );

    typedef struct packed {
        logic       clr;
        logic       vld;
        logic [2:0] cmd;
        logic [1:0] bg;
        logic       pre2;
        logic       crc;
        logic       wdbi;
        logic       rdbi;
        logic       dm;
        logic       pda;
        logic [4:0] ef;
        logic [2:0] ec;
        logic [3:0] req;
    } vec_t;

    function automatic vec_t mk(logic clr, logic vld, logic [2:0] cmd, logic [1:0] bg,
                                logic pre2, logic crc, logic wdbi, logic rdbi, logic dm,
                                logic pda, logic [4:0] ef, logic [2:0] ec, logic [3:0] req);
        return '{clr, vld, cmd, bg, pre2, crc, wdbi, rdbi, dm, pda, ef, ec, req};
    endfunction

    localparam int NV = 54;
    // One row per clock; expectations sampled just after that clock edge
    localparam vec_t VECS [NV] = '{
        mk(0,1,1,0,0,1,0,0,0,0,5'b00000,0,12), // 0  first write after reset: R12
        mk(0,0,0,0,0,1,0,0,0,0,5'b00000,0,1),
        mk(0,0,0,0,0,1,0,0,0,0,5'b00000,0,1),
        mk(0,0,0,0,0,1,0,0,0,0,5'b00000,0,1),
        mk(0,1,1,0,0,1,0,0,0,0,5'b00001,1,1),  // 4  same group gap 4: R1
        mk(1,0,0,0,0,1,0,0,0,0,5'b00000,0,11), // 5  clear: R11
        mk(0,0,0,0,0,1,0,0,0,0,5'b00000,0,1),
        mk(0,0,0,0,0,1,0,0,0,0,5'b00000,0,1),
        mk(0,1,1,1,0,1,0,0,0,0,5'b00010,2,3),  // 8  other group gap 4: R3
        mk(1,0,0,0,0,1,0,0,0,0,5'b00000,0,11),
        mk(0,1,1,0,1,1,0,0,0,0,5'b00001,1,2),  // 10 same group gap 6, 2tck: R2
        mk(1,0,0,0,1,1,0,0,0,0,5'b00000,0,11),
        mk(0,0,0,0,1,1,0,0,0,0,5'b00000,0,2),
        mk(0,0,0,0,1,1,0,0,0,0,5'b00000,0,2),
        mk(0,1,1,0,1,1,0,0,0,0,5'b00000,0,2),  // 14 gap 4 legal under 2tck: R2
        mk(0,0,0,0,1,1,0,0,0,0,5'b00000,0,2),
        mk(0,1,1,2,1,1,0,0,0,0,5'b00000,0,3),  // 16 other group gap 2
        mk(0,0,0,0,1,1,0,0,0,0,5'b00000,0,3),
        mk(0,0,0,0,1,1,0,0,0,0,5'b00000,0,3),
        mk(0,0,0,0,1,1,0,0,0,0,5'b00000,0,3),
        mk(0,0,0,0,1,1,0,0,0,0,5'b00000,0,3),
        mk(0,0,0,0,1,1,0,0,0,0,5'b00000,0,3),
        mk(0,1,1,3,1,1,0,0,0,0,5'b00010,2,3),  // 22 other group gap 6, 2tck: R3
        mk(1,0,0,0,0,1,0,0,0,0,5'b00000,0,11),
        mk(0,0,0,0,0,1,0,0,0,0,5'b00000,0,2),
        mk(0,0,0,0,0,1,0,0,0,0,5'b00000,0,2),
        mk(0,0,0,0,0,1,0,0,0,0,5'b00000,0,2),
        mk(0,0,0,0,0,1,0,0,0,0,5'b00000,0,2),
        mk(0,1,1,3,0,1,0,0,0,0,5'b00000,0,2),  // 28 gap 6 legal under 1tck: R2
        mk(0,0,0,0,0,1,0,0,0,0,5'b00000,0,1),
        mk(0,1,1,1,0,1,0,0,0,0,5'b00000,0,1),  // 30 unrelated group in between
        mk(0,0,0,0,0,1,0,0,0,0,5'b00000,0,1),
        mk(0,1,1,3,0,1,0,0,0,0,5'b00001,1,1),  // 32 same group gap 4 despite other write: R1
        mk(1,0,0,0,0,1,0,0,0,0,5'b00000,0,11),
        mk(0,1,3,0,0,1,0,0,0,0,5'b00100,3,4),  // 34 special-register write: R4
        mk(1,0,0,0,0,1,0,0,0,0,5'b00000,0,11),
        mk(0,1,2,3,0,1,0,0,0,0,5'b00000,0,1),  // 36 read at gap 4 ignored: R1
        mk(0,0,0,0,0,1,0,0,0,1,5'b01000,4,5),  // 37 per-device addressing: R5
        mk(1,0,0,0,0,1,0,0,0,0,5'b00000,0,11),
        mk(0,0,0,0,0,1,1,0,1,0,5'b10000,5,6),  // 39 write inversion + mask: R6
        mk(1,0,0,0,0,1,0,0,0,0,5'b00000,0,11),
        mk(0,0,0,0,0,1,0,1,1,0,5'b00000,0,6),  // 41 read inversion + mask legal: R6
        mk(0,1,3,0,0,0,1,0,1,1,5'b00000,0,8),  // 42 everything with CRC off: R8
        mk(0,1,1,2,0,0,0,0,0,0,5'b00000,0,8),  // 43 write with CRC off
        mk(0,0,0,0,0,0,0,0,0,0,5'b00000,0,8),
        mk(0,0,0,0,0,0,0,0,0,0,5'b00000,0,8),
        mk(0,0,0,0,0,0,0,0,0,0,5'b00000,0,8),
        mk(0,1,1,2,0,1,0,0,0,0,5'b00001,1,8),  // 47 history kept while off: R8
        mk(0,0,0,0,0,1,0,0,0,1,5'b01001,1,10), // 48 code keeps first: R10
        mk(0,0,0,0,0,1,0,0,0,0,5'b01001,1,9),  // 49 sticky: R9
        mk(1,0,0,0,0,1,0,0,0,0,5'b00000,0,11),
        mk(0,1,3,0,0,1,1,0,1,1,5'b11100,3,10), // 51 tie, lowest code: R10
        mk(1,0,0,0,0,1,0,0,0,1,5'b00000,0,11), // 52 clear beats hit: R11
        mk(0,0,0,0,0,1,0,0,0,0,5'b00000,0,11)
    };

    task automatic drive(logic clr, logic vld, logic [2:0] cmd, logic [1:0] bg, logic pre2,
                         logic crc, logic wdbi, logic rdbi, logic dm, logic pda);
        @(negedge clk);
        clear = clr; cmd_valid = vld; cmd_type = cmd; bank_group = bg;
        wr_pre_2tck = pre2; crc_en = crc; wr_dbi_en = wdbi; rd_dbi_en = rdbi;
        dm_en = dm; pda_en = pda;
        @(posedge clk);
        #1;
    endtask

    task automatic check(logic [4:0] ef, logic [2:0] ec, string tag);
        checks++;
        if (viol_flags !== ef || viol_code !== ec) begin
            errors++;
            $display("FAIL %s: flags=%b code=%0d expected flags=%b code=%0d",
                     tag, viol_flags, viol_code, ef, ec);
        end
    endtask

    task automatic idle_n(int n);
        for (int k = 0; k < n; k++) drive(0,0,0,0,0,1,0,0,0,0);
    endtask

    initial begin
        rst_n = 1'b0; clear = 1'b0; cmd_valid = 1'b0; cmd_type = 3'd0; bank_group = 2'd0;
        wr_pre_2tck = 1'b0; crc_en = 1'b1; wr_dbi_en = 1'b0; rd_dbi_en = 1'b0;
        dm_en = 1'b0; pda_en = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(5'b0, 3'd0, "R12 reset state");
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].clr, VECS[i].vld, VECS[i].cmd, VECS[i].bg, VECS[i].pre2,
                  VECS[i].crc, VECS[i].wdbi, VECS[i].rdbi, VECS[i].dm, VECS[i].pda);
            check(VECS[i].ef, VECS[i].ec, $sformatf("R%0d row %0d", VECS[i].req, i));
        end

        // R7: gap of 20 must not alias to 4
        drive(0,1,1,1,0,1,0,0,0,0);
        check(5'b0, 3'd0, "R7 first write");
        idle_n(19);
        drive(0,1,1,1,0,1,0,0,0,0);
        check(5'b0, 3'd0, "R7 gap 20 saturated");
        idle_n(3);
        drive(0,1,1,1,0,1,0,0,0,0);
        check(5'b00001, 3'd1, "R7 gap 4 after saturation");

        // R12: reset erases flags and write history
        drive(0,1,1,0,0,1,0,0,0,0);
        drive(0,0,0,0,0,1,0,0,0,0);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check(5'b0, 3'd0, "R12 reset clears flags");
        @(negedge clk);
        rst_n = 1'b1;
        drive(0,1,1,0,0,1,0,0,0,0);
        check(5'b0, 3'd0, "R12 history gone after reset");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule